// File: doc/BRIEF.md
# Successive-Approximation Control Register

This block holds the digital side of a successive-approximation converter. An outside DAC turns its parallel word into an analog level, and a comparator reports each trial back on a single data input. After a start, the block sets one trial bit per clock, beginning with the most significant bit. On the next clock it keeps or drops that bit according to the comparator. When the least significant bit has been decided, the block holds the result and raises a completion flag one clock later.

Each decided bit also appears on a serial output in the cycle after its decision, so the result leaves the block MSB first as it is built. A start needs either a rising start-convert level sampled across two clock edges or the release of the hold-reset input while start-convert is high. The block leaves its reset state only on one of these two events. This stable reset state is what lets it act as the lower stage of a cascade, waiting for the upper stage to hand over. All inputs are sampled on the rising clock edge.

Top module: `sar_register`

## Requirements
- R1: After the synchronous `rst`, `q_out`, `eoc` and `ser_out` are all 0 and the block is idle.
- R2: With `hold_rst`=1 at a clock edge, `q_out`, `eoc` and `ser_out` are 0 after that edge, whatever `start_cv` is.
- R3: A start occurs when `start_cv`=1 at an edge, `start_cv` was 0 at the previous edge, and `hold_rst` is 0 at both edges. After that edge, `q_out` holds only bit W-1 set, and `eoc` and `ser_out` are 0.
- R4: A start also occurs when `start_cv`=1 and `hold_rst`=0 at an edge while `hold_rst` was 1 at the previous edge. This holds whatever `start_cv` was at the previous edge.
- R5: While `start_cv` stays 1 at consecutive edges with `hold_rst` low, no new start occurs. A finished result and `eoc`=1 are held.
- R6: After `hold_rst` is released with `start_cv`=0, the outputs stay 0 for as long as `start_cv` stays 0.
- R7: At each decision edge for bit i, `q_out[i]` takes `cmp_in` (1 keeps the trial bit, 0 clears it) and bit i-1 is set as the next trial. Bits above i do not change.
- R8: After a decision edge, `ser_out` equals the bit just decided. At every other time, including reset and the cycle after a start, `ser_out` is 0.
- R9: `eoc` rises on the edge after bit 0 is decided and stays high with the result. It is cleared by a new start or by `hold_rst`.
- R10: When `cmp_in` reports 1 exactly when the analog input is at least the current `q_out`, the final `q_out` equals the analog input code, for every code.
- R11: A rising `start_cv` during a conversion abandons it and restarts at bit W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| start_cv | input | 1 | Start-convert level; a start needs a rise across two edges |
| cmp_in | input | 1 | Comparator result for the current trial bit |
| hold_rst | input | 1 | Synchronous hold reset; clears the register and parks it idle |
| q_out | output | W | Parallel trial/result word to the DAC |
| eoc | output | 1 | Conversion complete; the result on `q_out` is valid |
| ser_out | output | 1 | Decided bits, MSB first, one per cycle |

## Verification
The hardest situations to reach are the ones that depend on the history of two inputs across an edge. Examples are releasing `hold_rst` while `start_cv` is already high, compared with releasing it while `start_cv` is low, and holding `start_cv` high through and past a whole conversion. The bench reaches them by placing `hold_rst` and `start_cv` changes on chosen edges in the middle of conversions. It also raises `start_cv` again partway through a conversion. The main sweep runs a full conversion for every input code, with a comparator model driven from the live `q_out`.

// File: rtl/sar_reg_pkg.sv
package sar_reg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_reg_ctrl.sv
module sar_reg_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sc_i,
  input  logic mr_i,
  output logic start_o,
  output logic clear_o
);
  logic sc_q;
  logic mr_q;

  // Previous-edge samples are taken in every cycle, reset included, so that
  // a start-convert level held through reset never counts as a rising edge.
  always_ff @(posedge clk) begin
    sc_q <= sc_i;
    mr_q <= mr_i;
  end

  assign clear_o = mr_i;
  assign start_o = sc_i & ~mr_i & (~sc_q | mr_q);

  AST_HELD_SC_NO_START: assert property (@(posedge clk) disable iff (rst)
    (sc_i && $past(sc_i) && !$past(mr_i) && !mr_i) |-> !start_o); // R5
  AST_MR_RELEASE_STARTS: assert property (@(posedge clk) disable iff (rst)
    ($past(mr_i) && !mr_i && sc_i) |-> start_o); // R4
endmodule

// File: rtl/sar_reg_seq.sv
module sar_reg_seq
  import sar_reg_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          start_i,
  output sar_state_e    state_o,
  output logic [PW-1:0] ptr_o,
  output logic          decide_o,
  output logic          eoc_o
);
  localparam logic [PW-1:0] PTR_TOP = PW'(W - 1);

  sar_state_e    st;
  logic [PW-1:0] ptr;
  logic          eoc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      st    <= ST_IDLE;
      ptr   <= '0;
      eoc_q <= 1'b0;
    end else if (start_i) begin
      st    <= ST_RUN;
      ptr   <= PTR_TOP;
      eoc_q <= 1'b0;
    end else begin
      case (st)
        ST_RUN: begin
          if (ptr == '0) st <= ST_SETTLE;
          else           ptr <= ptr - 1'b1;
        end
        ST_SETTLE: begin
          st    <= ST_DONE;
          eoc_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o  = st;
  assign ptr_o    = ptr;
  assign eoc_o    = eoc_q;
  assign decide_o = (st == ST_RUN) && !start_i && !clear_i;

  AST_EOC_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_o) |-> $past(st) == ST_SETTLE); // R9
  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !start_i) |=> st == ST_IDLE); // R6
  AST_LAST_DECIDE_SETTLES: assert property (@(posedge clk) disable iff (rst)
    (decide_o && ptr == '0) |=> (st == ST_SETTLE && !eoc_o)); // R9
endmodule

// File: rtl/sar_reg_datapath.sv
module sar_reg_datapath #(
  parameter int W  = 8,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic          decide_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          d_i,
  output logic [W-1:0]  q_o,
  output logic          ser_o
);
  localparam logic [W-1:0] TRIAL_MSB = {1'b1, {(W-1){1'b0}}};

  // Resolve the bit at pos to bit_val and raise the next lower trial bit.
  function automatic logic [W-1:0] resolve_bit(input logic [W-1:0] cur,
                                               input logic [PW-1:0] pos,
                                               input logic bit_val);
    logic [W-1:0] nxt;
    nxt = cur;
    for (int i = 0; i < W; i++) begin
      if (i == int'(pos))     nxt[i] = bit_val;
      if (i + 1 == int'(pos)) nxt[i] = 1'b1;
    end
    return nxt;
  endfunction

  logic [W-1:0] q_q;
  logic         ser_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      q_q   <= '0;
      ser_q <= 1'b0;
    end else if (start_i) begin
      q_q   <= TRIAL_MSB;
      ser_q <= 1'b0;
    end else if (decide_i) begin
      q_q   <= resolve_bit(q_q, ptr_i, d_i);
      ser_q <= d_i;
    end else begin
      ser_q <= 1'b0;
    end
  end

  assign q_o   = q_q;
  assign ser_o = ser_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (q_o == '0 && ser_o == 1'b0)); // R2
  AST_START_MSB: assert property (@(posedge clk) disable iff (rst)
    (start_i && !clear_i) |=> (q_o == TRIAL_MSB && ser_o == 1'b0)); // R3
  AST_SER_TRACKS_D: assert property (@(posedge clk) disable iff (rst)
    decide_i |=> ser_o == $past(d_i)); // R8
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    decide_i |=> ((q_o >> (int'($past(ptr_i)) + 1)) ==
                  ($past(q_o) >> (int'($past(ptr_i)) + 1)))); // R7
endmodule

// File: rtl/sar_register.sv
module sar_register
  import sar_reg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_cv,
  input  logic         cmp_in,
  input  logic         hold_rst,
  output logic [W-1:0] q_out,
  output logic         eoc,
  output logic         ser_out
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;

  logic          start_w;
  logic          clear_w;
  logic          decide_w;
  logic [PW-1:0] ptr_w;
  sar_state_e    state_w;

  sar_reg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sc_i    (start_cv),
    .mr_i    (hold_rst),
    .start_o (start_w),
    .clear_o (clear_w)
  );

  sar_reg_seq #(.W(W), .PW(PW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear_w),
    .start_i  (start_w),
    .state_o  (state_w),
    .ptr_o    (ptr_w),
    .decide_o (decide_w),
    .eoc_o    (eoc)
  );

  sar_reg_datapath #(.W(W), .PW(PW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear_w),
    .start_i  (start_w),
    .decide_i (decide_w),
    .ptr_i    (ptr_w),
    .d_i      (cmp_in),
    .q_o      (q_out),
    .ser_o    (ser_out)
  );

  AST_EOC_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (eoc && state_w == ST_DONE && !start_w && !clear_w) |=> (eoc && $stable(q_out))); // R5
endmodule

// File: tb/sar_register_tb.sv
module sar_register_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_cv = 1'b0;
  logic         cmp_in = 1'b0;
  logic         hold_rst = 1'b0;
  logic [W-1:0] q_out;
  logic         eoc;
  logic         ser_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sar_register #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start_cv (start_cv),
    .cmp_in   (cmp_in),
    .hold_rst (hold_rst),
    .q_out    (q_out),
    .eoc      (eoc),
    .ser_out  (ser_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at the negedge after a start edge; decides nbits bits, MSB first.
  task automatic run_bits(input int vin, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      int i;
      int exp_q;
      i = W - 1 - k;
      exp_q = (vin & ~((1 << (i + 1)) - 1)) | (1 << i);
      check(q_out == exp_q[W-1:0], "R7 trial word", int'(q_out), exp_q);
      if (k > 0)
        check(ser_out == vin[i+1], "R8 serial bit", int'(ser_out), int'(vin[i+1]));
      else
        check(ser_out == 1'b0, "R8 serial idle after start", int'(ser_out), 0);
      cmp_in = (vin >= int'(q_out));
      tick();
    end
    if (nbits == W) begin
      check(ser_out == vin[0], "R8 serial lsb", int'(ser_out), int'(vin[0]));
      check(eoc == 1'b0, "R9 eoc low at lsb decision", int'(eoc), 0);
      tick();
      check(eoc == 1'b1, "R9 eoc raised", int'(eoc), 1);
      check(q_out == vin[W-1:0], "R10 final result", int'(q_out), vin);
      check(ser_out == 1'b0, "R8 serial low after conversion", int'(ser_out), 0);
    end
  endtask

  task automatic do_start(input bit hold_sc);
    start_cv = 1'b1;
    tick();
    check(q_out == 8'h80, "R3 start word", int'(q_out), 'h80);
    check(eoc == 1'b0, "R9 eoc cleared by start", int'(eoc), 0);
    check(ser_out == 1'b0, "R8 serial low on start", int'(ser_out), 0);
    if (!hold_sc) start_cv = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(q_out == '0 && eoc == 1'b0 && ser_out == 1'b0, "R1 reset state",
          int'({eoc, ser_out, q_out}), 0);

    // Sweep every code
    for (int v = 0; v < (1 << W); v++) begin
      do_start(1'b0);
      run_bits(v, W);
    end

    // R5: start-convert held high through and past a conversion
    do_start(1'b1);
    run_bits('hA5, W);
    for (int c = 0; c < 5; c++) begin
      tick();
      check(eoc == 1'b1 && q_out == 8'hA5, "R5 held result",
            int'({eoc, q_out}), 'h1A5);
    end
    // R2: hold reset clears a finished result, with start-convert high
    hold_rst = 1'b1;
    tick();
    check(q_out == '0 && eoc == 1'b0 && ser_out == 1'b0, "R2 clear after done",
          int'({eoc, ser_out, q_out}), 0);
    hold_rst = 1'b0;
    start_cv = 1'b0;
    tick();
    check(q_out == '0 && eoc == 1'b0, "R6 idle after release", int'({eoc, q_out}), 0);

    // R2 mid-conversion, then R6 parking with start-convert low
    do_start(1'b0);
    run_bits('h3C, 3);
    hold_rst = 1'b1;
    start_cv = 1'b1;
    tick();
    check(q_out == '0 && eoc == 1'b0 && ser_out == 1'b0, "R2 clear mid conversion",
          int'({eoc, ser_out, q_out}), 0);
    hold_rst = 1'b0;
    start_cv = 1'b0;
    for (int c = 0; c < 4; c++) begin
      tick();
      check(q_out == '0 && eoc == 1'b0 && ser_out == 1'b0, "R6 stays parked",
            int'({eoc, ser_out, q_out}), 0);
    end
    do_start(1'b0);
    run_bits('h3C, W);

    // R4: release of hold reset with start-convert already high
    hold_rst = 1'b1;
    start_cv = 1'b1;
    tick();
    tick();
    hold_rst = 1'b0;
    tick();
    check(q_out == 8'h80 && eoc == 1'b0, "R4 start on release", int'({eoc, q_out}), 'h80);
    run_bits('h5A, W);
    start_cv = 1'b0;
    tick();

    // R11: restart in the middle of a conversion
    do_start(1'b0);
    run_bits('hF0, 4);
    start_cv = 1'b1;
    tick();
    check(q_out == 8'h80, "R11 restart word", int'(q_out), 'h80);
    start_cv = 1'b0;
    run_bits('h0F, W);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule